// File: doc/BRIEF.md
# Code Phase Slew and Preset Sequencer

This block sits beside the code generator of one tracking channel and decides when that generator's phase is moved. Software writes four registers through a simple write port: control, code DCO phase, code slew and epoch load. The block also sees two timing strobes: the correlator dump and the measurement TIC. It turns these inputs into single-cycle commands for the code path. A slew command gives a relative shift in half-chip units. A phase-load command forces the code DCO phase. An epoch-load command presets the epoch counter. A code-select output carries the satellite code selection in force.

In update mode, which is the default after reset, a written slew, phase or epoch value is applied once, at the first dump after the write. In preset mode, all written values are only staged. The channel keeps running on its old settings. The epoch-load write arms the sequencer, so it must be the last write of the sequence. At the next TIC, every staged value is applied in the same cycle, and the code DCO phase is forced to the staged value whatever it held before. The carrier DCO and the carrier cycle counter have no connection to this block.

The sequencer has three states. `ST_UPDATE` is the update mode. `ST_STAGING` is preset mode with nothing armed yet. `ST_ARMED` is preset mode waiting for a TIC. The transitions are as follows:
- A control write with the preset bit set goes to `ST_STAGING` from any state.
- A control write with the bit clear goes to `ST_UPDATE` from any state.
- An epoch write in `ST_STAGING` goes to `ST_ARMED`.
- A TIC in `ST_ARMED` performs the load and returns to `ST_STAGING`. If an epoch write arrives in that same cycle, the state stays `ST_ARMED`.

A control write has priority over every other transition.

Top module: `code_slew_preset`

## Requirements
- R1: While reset is held and in the first cycle after it, all three fire outputs are low, all value outputs are zero and `code_sel` is zero.
- R2: The write port decodes `wr_sel` as follows: 0 is control, 1 is code phase, 2 is slew, 3 is epoch. In update mode, a slew write gives exactly one `slew_fire` pulse. The pulse comes in the cycle after the next `dump`, and `slew_amt` equals the written value in half-chip units, so one whole chip is 2. `slew_amt`, `phase_val` and `epoch_val` are zero whenever their fire output is low.
- R3: A slew is not repeated. A further `dump` without a new slew write gives no `slew_fire`. Writing the same amount again gives a new pulse at the following dump.
- R4: If several slew writes arrive before a dump, only the last value is used. A slew write in the same cycle as a `dump` does not join that dump. That dump fires the earlier pending value, and the new value fires at the next dump.
- R5: In update mode, a phase write and an epoch write each fire once at the next `dump`, through `phase_fire`/`phase_val` and `epoch_fire`/`epoch_val`.
- R6: The control word uses bit 0 as the preset bit and bits 6:1 as the code selection. A control write with bit 0 clear sets `code_sel` in the next cycle and cancels every pending slew, phase or epoch command.
- R7: A control write with bit 0 set enters preset mode. While in preset mode, a `dump` fires nothing and `code_sel` keeps its old value until a preset load.
- R8: In preset mode, a TIC that arrives before any epoch write does nothing.
- R9: After arming, the next TIC fires `phase_fire` and `epoch_fire` together with the staged values, and loads the staged selection into `code_sel` in that same cycle. `slew_fire` joins them only if a slew was written since the last load or control write.
- R10: Only an epoch write made in preset mode arms the load. A TIC in the same cycle as that write does not load. Phase or slew writes made after arming change the values loaded.
- R11: After a preset load the block is disarmed and stays in preset mode. A further TIC or dump fires nothing until the next epoch write.
- R12: A control write made while armed disarms the sequencer, so the following TIC fires nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 phase, 2 slew, 3 epoch |
| wr_data | input | DATA_W | Write data |
| dump | input | 1 | Correlator dump strobe |
| tic | input | 1 | Measurement TIC strobe |
| slew_fire | output | 1 | One-cycle relative slew command |
| slew_amt | output | SLEW_W | Slew amount in half chips, zero when idle |
| phase_fire | output | 1 | One-cycle code DCO phase load |
| phase_val | output | PHASE_W | Phase value to load, zero when idle |
| epoch_fire | output | 1 | One-cycle epoch counter load |
| epoch_val | output | EPOCH_W | Epoch value to load, zero when idle |
| code_sel | output | SAT_W | Satellite code selection in force |

## Verification
The bench aims at the timing edges of the strobes. It covers a slew written in the same cycle as a dump, which a wrong design would either fire early or drop. It covers a repeated dump after a single slew write, which a level-based design would turn into a second shift. It covers a TIC that arrives in the same cycle as the arming epoch write, which a design without a registered arm flag would load too early. In preset mode, the bench checks that dumps and unarmed TICs leave the commands and `code_sel` untouched, that writes made after arming are the ones loaded, that a second TIC finds the sequencer disarmed, and that a control write cancels both an armed load and a pending update-mode slew.

// File: rtl/csp_pkg.sv
package csp_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_PHASE = 2'd1,
        SEL_SLEW  = 2'd2,
        SEL_EPOCH = 2'd3
    } wsel_e;

    typedef enum logic [1:0] {
        ST_UPDATE  = 2'd0,
        ST_STAGING = 2'd1,
        ST_ARMED   = 2'd2
    } state_e;

    localparam int CTRL_PRESET_BIT = 0;
    localparam int CTRL_SEL_LSB    = 1;

endpackage

// File: rtl/csp_seq_fsm.sv
module csp_seq_fsm
    import csp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ctrl_wr,
    input  logic   ctrl_preset,
    input  logic   epoch_wr,
    input  logic   dump,
    input  logic   tic,
    output state_e state_q,
    output logic   upd_fire,
    output logic   preset_load
);

    state_e state_d;

    // next-state selection; a control write overrides every other event
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UPDATE: begin
                if (ctrl_wr && ctrl_preset)
                    state_d = ST_STAGING;
            end
            ST_STAGING: begin
                if (ctrl_wr)
                    state_d = ctrl_preset ? ST_STAGING : ST_UPDATE;
                else if (epoch_wr)
                    state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (ctrl_wr)
                    state_d = ctrl_preset ? ST_STAGING : ST_UPDATE;
                else if (tic)
                    state_d = epoch_wr ? ST_ARMED : ST_STAGING;
            end
            default: state_d = ST_UPDATE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_UPDATE;
        else
            state_q <= state_d;
    end

    // state-decoded trigger outputs
    always_comb begin
        upd_fire    = 1'b0;
        preset_load = 1'b0;
        unique case (state_q)
            ST_UPDATE:  upd_fire    = dump;
            ST_STAGING: ;
            ST_ARMED:   preset_load = tic;
            default: ;
        endcase
    end

endmodule

// File: rtl/csp_stage_slot.sv
module csp_stage_slot #(
    parameter int W      = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              cancel,
    input  logic              consume,
    input  logic [DATA_W-1:0] data,
    output logic [W-1:0]      val,
    output logic              pend
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val  <= '0;
            pend <= 1'b0;
        end else begin
            if (wr)
                val <= data[W-1:0];
            // a write in the consuming cycle stays pending for the next trigger
            if (wr)
                pend <= 1'b1;
            else if (cancel || consume)
                pend <= 1'b0;
        end
    end

endmodule

// File: rtl/csp_cmd_out.sv
module csp_cmd_out #(
    parameter int SLEW_W  = 11,
    parameter int PHASE_W = 10,
    parameter int EPOCH_W = 11,
    parameter int SAT_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_wr,
    input  logic               ctrl_preset,
    input  logic [SAT_W-1:0]   ctrl_sel,
    input  logic               upd_fire,
    input  logic               preset_load,
    input  logic               slew_pend,
    input  logic [SLEW_W-1:0]  slew_stage,
    input  logic               phase_pend,
    input  logic [PHASE_W-1:0] phase_stage,
    input  logic               epoch_pend,
    input  logic [EPOCH_W-1:0] epoch_stage,
    output logic               slew_fire,
    output logic [SLEW_W-1:0]  slew_amt,
    output logic               phase_fire,
    output logic [PHASE_W-1:0] phase_val,
    output logic               epoch_fire,
    output logic [EPOCH_W-1:0] epoch_val,
    output logic [SAT_W-1:0]   code_sel
);

    logic             go_slew;
    logic             go_phase;
    logic             go_epoch;
    logic [SAT_W-1:0] sel_stage;

    always_comb begin
        go_slew  = (upd_fire || preset_load) && slew_pend;
        go_phase = (upd_fire && phase_pend) || preset_load;
        go_epoch = (upd_fire && epoch_pend) || preset_load;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slew_fire  <= 1'b0;
            slew_amt   <= '0;
            phase_fire <= 1'b0;
            phase_val  <= '0;
            epoch_fire <= 1'b0;
            epoch_val  <= '0;
        end else begin
            slew_fire  <= go_slew;
            slew_amt   <= go_slew  ? slew_stage  : '0;
            phase_fire <= go_phase;
            phase_val  <= go_phase ? phase_stage : '0;
            epoch_fire <= go_epoch;
            epoch_val  <= go_epoch ? epoch_stage : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_stage <= '0;
            code_sel  <= '0;
        end else begin
            if (ctrl_wr)
                sel_stage <= ctrl_sel;
            if (ctrl_wr && !ctrl_preset)
                code_sel <= ctrl_sel;
            else if (preset_load)
                code_sel <= sel_stage;
        end
    end

endmodule

// File: rtl/code_slew_preset.sv
module code_slew_preset
    import csp_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int SLEW_W  = 11,
    parameter int PHASE_W = 10,
    parameter int EPOCH_W = 11,
    parameter int SAT_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               dump,
    input  logic               tic,
    output logic               slew_fire,
    output logic [SLEW_W-1:0]  slew_amt,
    output logic               phase_fire,
    output logic [PHASE_W-1:0] phase_val,
    output logic               epoch_fire,
    output logic [EPOCH_W-1:0] epoch_val,
    output logic [SAT_W-1:0]   code_sel
);

    localparam int NSLOT = 3;
    localparam int SLOT_PHASE = 0;
    localparam int SLOT_SLEW  = 1;
    localparam int SLOT_EPOCH = 2;
    localparam int MAXW = (SLEW_W > PHASE_W) ? ((SLEW_W > EPOCH_W) ? SLEW_W : EPOCH_W)
                                             : ((PHASE_W > EPOCH_W) ? PHASE_W : EPOCH_W);

    logic             ctrl_wr;
    logic             ctrl_preset;
    logic [SAT_W-1:0] ctrl_sel;
    logic             upd_fire;
    logic             preset_load;
    state_e           state_q;

    logic [NSLOT-1:0] slot_wr;
    logic [NSLOT-1:0] slot_pend;
    logic [MAXW-1:0]  slot_val [NSLOT];

    always_comb begin
        ctrl_wr     = wr_en && (wr_sel == SEL_CTRL);
        ctrl_preset = wr_data[CTRL_PRESET_BIT];
        ctrl_sel    = wr_data[CTRL_SEL_LSB +: SAT_W];
        slot_wr[SLOT_PHASE] = wr_en && (wr_sel == SEL_PHASE);
        slot_wr[SLOT_SLEW]  = wr_en && (wr_sel == SEL_SLEW);
        slot_wr[SLOT_EPOCH] = wr_en && (wr_sel == SEL_EPOCH);
    end

    csp_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (ctrl_wr),
        .ctrl_preset (ctrl_preset),
        .epoch_wr    (slot_wr[SLOT_EPOCH]),
        .dump        (dump),
        .tic         (tic),
        .state_q     (state_q),
        .upd_fire    (upd_fire),
        .preset_load (preset_load)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        localparam int SW = (g == SLOT_PHASE) ? PHASE_W :
                            (g == SLOT_SLEW)  ? SLEW_W  : EPOCH_W;
        logic [SW-1:0] v;

        csp_stage_slot #(.W(SW), .DATA_W(DATA_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (slot_wr[g]),
            .cancel  (ctrl_wr),
            .consume (upd_fire || preset_load),
            .data    (wr_data),
            .val     (v),
            .pend    (slot_pend[g])
        );

        always_comb slot_val[g] = MAXW'(v);
    end

    csp_cmd_out #(
        .SLEW_W  (SLEW_W),
        .PHASE_W (PHASE_W),
        .EPOCH_W (EPOCH_W),
        .SAT_W   (SAT_W)
    ) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (ctrl_wr),
        .ctrl_preset (ctrl_preset),
        .ctrl_sel    (ctrl_sel),
        .upd_fire    (upd_fire),
        .preset_load (preset_load),
        .slew_pend   (slot_pend[SLOT_SLEW]),
        .slew_stage  (slot_val[SLOT_SLEW][SLEW_W-1:0]),
        .phase_pend  (slot_pend[SLOT_PHASE]),
        .phase_stage (slot_val[SLOT_PHASE][PHASE_W-1:0]),
        .epoch_pend  (slot_pend[SLOT_EPOCH]),
        .epoch_stage (slot_val[SLOT_EPOCH][EPOCH_W-1:0]),
        .slew_fire   (slew_fire),
        .slew_amt    (slew_amt),
        .phase_fire  (phase_fire),
        .phase_val   (phase_val),
        .epoch_fire  (epoch_fire),
        .epoch_val   (epoch_val),
        .code_sel    (code_sel)
    );

endmodule

// File: rtl/csp_checker.sv
module csp_checker
    import csp_pkg::*;
#(
    parameter int SLEW_W = 11,
    parameter int SAT_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic              dump,
    input logic              tic,
    input logic              slew_fire,
    input logic [SLEW_W-1:0] slew_amt,
    input logic              phase_fire,
    input logic              epoch_fire,
    input logic [SAT_W-1:0]  code_sel,
    input state_e            state_q
);

    logic ctrl_wr;
    logic epoch_wr;
    always_comb begin
        ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);
        epoch_wr = wr_en && (wr_sel == SEL_EPOCH);
    end

    assert_amt_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !slew_fire |-> slew_amt == '0);

    assert_slew_needs_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        slew_fire |-> ($past(dump) || $past(tic)));

    assert_preset_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STAGING && !ctrl_wr) |=>
            (!slew_fire && !phase_fire && !epoch_fire && $stable(code_sel)));

    assert_load_together_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && tic) |=> (phase_fire && epoch_fire));

    assert_arm_by_epoch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && $past(state_q) != ST_ARMED) |-> $past(epoch_wr));

    assert_disarm_after_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && tic && !wr_en) |=> state_q == ST_STAGING);

    assert_ctrl_disarms_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && ctrl_wr) |=> state_q != ST_ARMED);

endmodule

bind code_slew_preset csp_checker #(.SLEW_W(SLEW_W), .SAT_W(SAT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .dump       (dump),
    .tic        (tic),
    .slew_fire  (slew_fire),
    .slew_amt   (slew_amt),
    .phase_fire (phase_fire),
    .epoch_fire (epoch_fire),
    .code_sel   (code_sel),
    .state_q    (state_q)
);

// File: tb/code_slew_preset_test.sv
module code_slew_preset_test;

    localparam int DATA_W  = 16;
    localparam int SLEW_W  = 11;
    localparam int PHASE_W = 10;
    localparam int EPOCH_W = 11;
    localparam int SAT_W   = 6;

    localparam logic [1:0] W_CTRL  = 2'd0;
    localparam logic [1:0] W_PHASE = 2'd1;
    localparam logic [1:0] W_SLEW  = 2'd2;
    localparam logic [1:0] W_EPOCH = 2'd3;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               wr_en;
    logic [1:0]         wr_sel;
    logic [DATA_W-1:0]  wr_data;
    logic               dump;
    logic               tic;
    logic               slew_fire;
    logic [SLEW_W-1:0]  slew_amt;
    logic               phase_fire;
    logic [PHASE_W-1:0] phase_val;
    logic               epoch_fire;
    logic [EPOCH_W-1:0] epoch_val;
    logic [SAT_W-1:0]   code_sel;

    typedef struct packed {
        logic               sf;
        logic [SLEW_W-1:0]  sa;
        logic               pf;
        logic [PHASE_W-1:0] pv;
        logic               ef;
        logic [EPOCH_W-1:0] ev;
        logic [SAT_W-1:0]   cs;
    } rec_t;

    rec_t  exp_q[$];
    string tag_q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    run   = 1'b0;
    int    cycles = 0;

    always #5 clk = ~clk;

    code_slew_preset #(
        .DATA_W(DATA_W), .SLEW_W(SLEW_W), .PHASE_W(PHASE_W),
        .EPOCH_W(EPOCH_W), .SAT_W(SAT_W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .dump(dump), .tic(tic),
        .slew_fire(slew_fire), .slew_amt(slew_amt),
        .phase_fire(phase_fire), .phase_val(phase_val),
        .epoch_fire(epoch_fire), .epoch_val(epoch_val),
        .code_sel(code_sel)
    );

    function automatic rec_t observed();
        rec_t r;
        r.sf = slew_fire;  r.sa = slew_amt;
        r.pf = phase_fire; r.pv = phase_val;
        r.ef = epoch_fire; r.ev = epoch_val;
        r.cs = code_sel;
        return r;
    endfunction

    // driver side of the scoreboard
    task automatic push(string tag, logic sf, int sa, logic pf, int pv,
                        logic ef, int ev, int cs);
        rec_t r;
        r.sf = sf; r.sa = SLEW_W'(sa);
        r.pf = pf; r.pv = PHASE_W'(pv);
        r.ef = ef; r.ev = EPOCH_W'(ev);
        r.cs = SAT_W'(cs);
        exp_q.push_back(r);
        tag_q.push_back(tag);
    endtask

    // monitor side: every command pulse is popped and compared
    always @(negedge clk) begin
        if (run && (slew_fire || phase_fire || epoch_fire)) begin
            rec_t o;
            o = observed();
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected command: actual %h expected none", o);
            end else begin
                rec_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (o !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", t, o, e);
                end
            end
        end
    end

    task automatic step(logic we, logic [1:0] sel, int data, logic d, logic t);
        wr_en = we; wr_sel = sel; wr_data = DATA_W'(data);
        dump = d; tic = t;
        @(negedge clk);
        wr_en = 1'b0; dump = 1'b0; tic = 1'b0;
    endtask

    task automatic wr(logic [1:0] sel, int data);
        step(1'b1, sel, data, 1'b0, 1'b0);
    endtask

    task automatic check_quiet(string tag);
        n_chk++;
        if (slew_fire || phase_fire || epoch_fire) begin
            n_bad++;
            $display("FAIL %s: actual fires %b%b%b expected 000",
                     tag, slew_fire, phase_fire, epoch_fire);
        end
    endtask

    task automatic check_sel(string tag, int e);
        n_chk++;
        if (code_sel !== SAT_W'(e)) begin
            n_bad++;
            $display("FAIL %s: actual code_sel %0d expected %0d", tag, code_sel, e);
        end
    endtask

    function automatic int ctrl_word(int sel, int preset);
        return (sel << 1) | preset;
    endfunction

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        dump = 1'b0; tic = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state while held
        n_chk++;
        if (observed() !== '0) begin
            n_bad++;
            $display("FAIL R1: actual %h expected 0", observed());
        end
        rst_n = 1'b1;
        run   = 1'b1;
        @(negedge clk);
        check_quiet("R1");
        check_sel("R1", 0);

        // R2: one whole chip = 2 half chips, single pulse
        wr(W_SLEW, 2);
        push("R2", 1, 2, 0, 0, 0, 0, 0);
        step(0, '0, 0, 1, 0);
        @(negedge clk);
        check_quiet("R2");

        // R3: no repeat without rewrite, same value rewritten fires again
        step(0, '0, 0, 1, 0);
        check_quiet("R3");
        wr(W_SLEW, 2);
        push("R3", 1, 2, 0, 0, 0, 0, 0);
        step(0, '0, 0, 1, 0);

        // R4: last write wins; write in the dump cycle waits
        wr(W_SLEW, 5);
        wr(W_SLEW, 3);
        push("R4", 1, 3, 0, 0, 0, 0, 0);
        step(1, W_SLEW, 9, 1, 0);
        push("R4", 1, 9, 0, 0, 0, 0, 0);
        step(0, '0, 0, 1, 0);

        // R5: phase and epoch at next dump
        wr(W_EPOCH, 100);
        wr(W_PHASE, 33);
        push("R5", 0, 0, 1, 33, 1, 100, 0);
        step(0, '0, 0, 1, 0);

        // R6: update-mode control write sets selection and cancels pending
        wr(W_CTRL, ctrl_word(5, 0));
        check_sel("R6", 5);
        wr(W_SLEW, 4);
        wr(W_CTRL, ctrl_word(6, 0));
        check_sel("R6", 6);
        step(0, '0, 0, 1, 0);
        check_quiet("R6");

        // R7: preset mode holds everything back
        wr(W_CTRL, ctrl_word(9, 1));
        check_sel("R7", 6);
        wr(W_SLEW, 6);
        wr(W_PHASE, 200);
        step(0, '0, 0, 1, 0);
        check_quiet("R7");
        check_sel("R7", 6);

        // R8: TIC before arming does nothing
        step(0, '0, 0, 0, 1);
        check_quiet("R8");
        check_sel("R8", 6);

        // R10: TIC in the arming cycle does not load
        step(1, W_EPOCH, 300, 0, 1);
        check_quiet("R10");
        step(0, '0, 0, 1, 0);
        check_quiet("R7");
        wr(W_PHASE, 201);

        // R9: armed TIC loads all staged values together
        push("R9", 1, 6, 1, 201, 1, 300, 9);
        step(0, '0, 0, 0, 1);
        check_sel("R9", 9);

        // R11: disarmed after load, still preset
        step(0, '0, 0, 0, 1);
        check_quiet("R11");
        step(0, '0, 0, 1, 0);
        check_quiet("R11");

        // R9: load without a fresh slew write gives no slew
        wr(W_EPOCH, 50);
        push("R9", 0, 0, 1, 201, 1, 50, 9);
        step(0, '0, 0, 0, 1);

        // R12: control write disarms
        wr(W_EPOCH, 60);
        wr(W_CTRL, ctrl_word(12, 1));
        step(0, '0, 0, 0, 1);
        check_quiet("R12");
        check_sel("R12", 9);
        wr(W_CTRL, ctrl_word(3, 0));
        check_sel("R6", 3);
        step(0, '0, 0, 1, 0);
        check_quiet("R6");

        repeat (2) @(negedge clk);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL %s: actual %0d commands missing expected 0",
                     tag_q[0], exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule